// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine

This block moves data between memory locations, or between memory and a fixed I/O location, without the processor. It has two channels. Each one holds its own source address, destination address, unit count and control word, and all of these are written through a small register port. One simple bus master port is shared by both channels. Every unit is read from the source and then written to the destination. A unit is a byte, a half-word or a word. After each unit, each address can step up, step down or stay fixed.

A channel starts from a software start bit or from its own active-low request pin. There are three request modes. Single mode moves one unit, or a group of four units, for each request. Block mode empties the whole count from one request. Demand mode moves units while the request pin is held. When a channel's count reaches zero, it clears its enable bit and sets a done flag. If the channel's interrupt enable is set, the done flag also drives that channel's interrupt line. Software clears the done flag by writing a one to it.

Top module: `dma2ch_engine`

## Requirements
- R1: After reset the bus strobes, both interrupt lines and every readable register are zero.
- R2: Register addresses 0 to 3 are channel 0 source, destination, count and control, and 4 to 7 are the same four for channel 1. Address 8 is status: bit 0 is the channel 0 done flag and bit 1 is the channel 1 done flag. Written values read back, and the address and count registers read their current working values.
- R3: Control bits are: 0 enable, 2:1 size (0 byte, 1 half-word, 2 word), 3 source down, 4 destination down, 5 source fixed, 6 destination fixed, 8:7 mode (0 single, 1 block, 2 demand), 9 four-unit burst, 10 external trigger, 11 interrupt enable. Each unit is a read strobe with the source address, then a write strobe with the destination address in the next cycle. Data is right-aligned and carries the programmed size. Read data must be valid in the cycle after the read strobe.
- R4: After each unit, each address moves by the unit size in bytes (1, 2 or 4). It moves down if its down bit is set and up otherwise. It does not move if its fixed bit is set.
- R5: In single mode, each request moves one unit, or four units with burst on (fewer if the count runs out). With the external trigger bit clear, a request is a control write with bit 0 set.
- R6: In block mode, one request moves the whole count. With burst off, each unit takes three cycles, so the done flag is set on the 3N-th clock edge after the starting control write, for N units.
- R7: In demand mode, units move only while the synchronized request is asserted. Transfer pauses without losing the count when the request is released, and resumes when it returns.
- R8: When the count reaches zero, the enable bit clears and the done flag sets. The count only ever falls by one per unit written.
- R9: The interrupt line of a channel is its done flag gated by its interrupt enable. Writing one to a status bit clears that flag; nothing else clears it.
- R10: When both channels are ready, channel 0 wins. Arbitration happens only at unit boundaries, or at four-unit group boundaries when burst is on, so a group is never split.
- R11: Request pins pass through two flops. In single and block mode a request is a new assertion seen after synchronization, and the first read strobe appears three clock edges after the edge that first samples the low pin. A control write with the external trigger bit set does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xreq_n | input | 2 | Active-low external requests, one per channel |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_addr | output | AW | Bus byte address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| irq | output | 2 | Per-channel interrupt |

## Verification
A software start moves the first read strobe one edge after the control write. Each following unit adds three edges, or two inside a burst group. An external request adds three edges of synchronizer and edge-detect delay before the first read. The bench checks the done timing of a block transfer exactly at edge 3N and at edge 3N-1. It checks the request latency edge by edge after the pin falls. A reference model predicts every bus strobe in order, and each strobe is compared at the falling edge of the cycle in which it appears. Register reads happen only after a settle time well past the last expected strobe.

// File: rtl/dma2ch_engine.sv
module dma2ch_engine #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [1:0]    xreq_n,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [1:0]    irq
);
  localparam int CTLW = 12;
  localparam logic [1:0] M_SINGLE = 2'd0;
  localparam logic [1:0] M_DEMAND = 2'd2;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [AW-1:0]   src [2];
  logic [AW-1:0]   dst [2];
  logic [CW-1:0]   cnt [2];
  logic [CTLW-1:0] ctl [2];
  logic [1:0] done, pend, sy1, sy2, sy3, go;
  st_t        st;
  logic       ch;
  logic [1:0] beat;

  always_comb
    for (int c = 0; c < 2; c++)
      go[c] = ctl[c][0] && (cnt[c] != '0) &&
              ((ctl[c][8:7] == M_DEMAND) ? sy2[c] : pend[c]);

  wire [CTLW-1:0] cc   = ctl[ch];
  wire [1:0]      csz  = cc[2:1];
  wire [AW-1:0]   stp  = AW'(1) << csz;
  wire            last = cnt[ch] == CW'(1);
  wire            gend = !cc[9] || beat == 2'd3;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic dn,
                                        input logic fx, input logic [AW-1:0] s);
    return fx ? a : (dn ? a - s : a + s);
  endfunction

  assign mem_rd    = st == S_RD;
  assign mem_wr    = st == S_WR;
  assign mem_addr  = mem_wr ? dst[ch] : src[ch];
  assign mem_size  = csz;
  assign mem_wdata = (csz == 2'd0) ? {24'b0, mem_rdata[7:0]} :
                     (csz == 2'd1) ? {16'b0, mem_rdata[15:0]} : mem_rdata;
  assign irq       = done & {ctl[1][11], ctl[0][11]};

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 4'h8) reg_rdata = {30'b0, done};
    else if (!reg_addr[3])
      case (reg_addr[1:0])
        2'd0:    reg_rdata = 32'(src[reg_addr[2]]);
        2'd1:    reg_rdata = 32'(dst[reg_addr[2]]);
        2'd2:    reg_rdata = 32'(cnt[reg_addr[2]]);
        default: reg_rdata = 32'(ctl[reg_addr[2]]);
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        src[c] <= '0; dst[c] <= '0; cnt[c] <= '0; ctl[c] <= '0;
      end
      done <= '0; pend <= '0; sy1 <= '0; sy2 <= '0; sy3 <= '0;
      st <= S_IDLE; ch <= 1'b0; beat <= '0;
    end else begin
      sy1 <= ~xreq_n; sy2 <= sy1; sy3 <= sy2;
      if (reg_wr) begin
        if (reg_addr == 4'h8) done <= done & ~reg_wdata[1:0];
        else if (!reg_addr[3])
          case (reg_addr[1:0])
            2'd0: src[reg_addr[2]] <= reg_wdata[AW-1:0];
            2'd1: dst[reg_addr[2]] <= reg_wdata[AW-1:0];
            2'd2: cnt[reg_addr[2]] <= reg_wdata[CW-1:0];
            default: begin
              ctl[reg_addr[2]] <= reg_wdata[CTLW-1:0];
              if (reg_wdata[0] && !reg_wdata[10]) pend[reg_addr[2]] <= 1'b1;
            end
          endcase
      end
      for (int c = 0; c < 2; c++)
        if (ctl[c][0] && ctl[c][10] && sy2[c] && !sy3[c]) pend[c] <= 1'b1;
      case (st)
        S_IDLE: begin
          beat <= '0;
          if (go[0])      begin ch <= 1'b0; st <= S_RD; end
          else if (go[1]) begin ch <= 1'b1; st <= S_RD; end
        end
        S_RD: st <= S_WR;
        default: begin
          cnt[ch] <= cnt[ch] - CW'(1);
          src[ch] <= nxt(src[ch], cc[3], cc[5], stp);
          dst[ch] <= nxt(dst[ch], cc[4], cc[6], stp);
          if (last) begin
            ctl[ch][0] <= 1'b0; done[ch] <= 1'b1; pend[ch] <= 1'b0; st <= S_IDLE;
          end else if (gend) begin
            if (cc[8:7] == M_SINGLE) pend[ch] <= 1'b0;
            st <= S_IDLE;
          end else begin
            beat <= beat + 2'd1; st <= S_RD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma2ch_engine_chk.sv
module dma2ch_engine_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [1:0]    done,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic          en0,
  input logic          en1
);
  assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);
  assert_wr_needs_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  assert_cnt0_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && cnt0 != $past(cnt0)) |-> ($past(mem_wr) && cnt0 == $past(cnt0) - CW'(1)));
  assert_cnt1_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && cnt1 != $past(cnt1)) |-> ($past(mem_wr) && cnt1 == $past(cnt1) - CW'(1)));
  assert_done0_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> !en0);
  assert_done1_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[1]) |-> !en1);
  assert_done0_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done[0]) |-> ($past(reg_wr) && $past(reg_addr) == 4'h8));
  assert_done1_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done[1]) |-> ($past(reg_wr) && $past(reg_addr) == 4'h8));
endmodule

bind dma2ch_engine dma2ch_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .done(done),
  .cnt0(cnt[0]), .cnt1(cnt[1]), .en0(ctl[0][0]), .en1(ctl[1][0])
);

// File: tb/tb_dma2ch_engine.sv
module tb_dma2ch_engine;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0] xreq_n = 2'b11;
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0] irq;

  always #5 clk = ~clk;

  dma2ch_engine #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xreq_n(xreq_n),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq));

  typedef struct packed { logic [31:0] a; logic w; logic [1:0] s; } tx_t;
  logic [7:0] mem  [1024];
  logic [7:0] refm [1024];
  tx_t q0[$];
  tx_t q1[$];
  int order[$];
  int ntx = 0;
  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= '0;
      for (int i = 0; i < 4; i++)
        if (i < (1 << mem_size)) mem_rdata[8*i +: 8] <= mem[10'(mem_addr + 32'(i))];
    end
    if (mem_wr)
      for (int i = 0; i < 4; i++)
        if (i < (1 << mem_size)) mem[10'(mem_addr + 32'(i))] <= mem_wdata[8*i +: 8];
  end

  // reference comparison of every bus strobe, one per cycle
  always @(negedge clk) begin
    tx_t e;
    int c;
    if (rst_n && (mem_rd || mem_wr)) begin
      c = int'(mem_addr[9]);
      ntx++;
      order.push_back(c);
      if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0))
        chk(0, "R3/R4 unexpected strobe", mem_addr, 0);
      else begin
        e = (c == 0) ? q0.pop_front() : q1.pop_front();
        chk(e.a == mem_addr && e.w == mem_wr && e.s == mem_size,
            "R3/R4 strobe", {mem_addr[28:0], mem_wr, mem_size}, {e.a[28:0], e.w, e.s});
      end
    end
  end

  function automatic logic [31:0] cw(bit en, logic [1:0] sz, bit sdn, bit ddn, bit sfx, bit dfx,
                                     logic [1:0] md, bit bu, bit ex, bit ie);
    return {20'b0, ie, ex, bu, md, dfx, sfx, ddn, sdn, sz, en};
  endfunction

  task automatic plan(input int c, input logic [31:0] s0, input logic [31:0] d0, input int n,
                      input logic [1:0] sz, input bit sdn, input bit ddn, input bit sfx, input bit dfx);
    logic [31:0] s = s0;
    logic [31:0] d = d0;
    logic [31:0] st = 32'(1) << sz;
    for (int u = 0; u < n; u++) begin
      for (int b = 0; b < (1 << sz); b++) refm[10'(d + 32'(b))] = refm[10'(s + 32'(b))];
      if (c == 0) begin q0.push_back({s, 1'b0, sz}); q0.push_back({d, 1'b1, sz}); end
      else        begin q1.push_back({s, 1'b0, sz}); q1.push_back({d, 1'b1, sz}); end
      if (!sfx) s = sdn ? s - st : s + st;
      if (!dfx) d = ddn ? d - st : d + st;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d, input int n);
    wr(4'(4*c + 0), s);
    wr(4'(4*c + 1), d);
    wr(4'(4*c + 2), 32'(n));
  endtask

  task automatic wait_done(input int c, input string req);
    logic [31:0] v = '0;
    for (int k = 0; k < 3000; k++) begin
      rd(4'h8, v);
      if (v[c]) break;
      @(negedge clk);
    end
    chk(v[c] == 1'b1, req, v, 32'(1 << c));
  endtask

  task automatic cmp(input string req);
    int m = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) m++;
    chk(m == 0, req, 32'(m), 0);
    chk(q0.size() == 0 && q1.size() == 0, req, 32'(q0.size() + q1.size()), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n0;
    int ok;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'((i * 37 + 11) & 255);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!mem_rd && !mem_wr && irq == 2'b00, "R1 strobes/irq", {mem_rd, mem_wr, irq}, 0);
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      chk(v == 0, "R1 register", v, 0);
    end

    // R2 readback
    prog(1, 32'h240, 32'h2A0, 7);
    wr(4'h7, cw(0, 2, 1, 0, 0, 1, 1, 1, 0, 1));
    rd(4'h4, v); chk(v == 32'h240, "R2 src1", v, 32'h240);
    rd(4'h5, v); chk(v == 32'h2A0, "R2 dst1", v, 32'h2A0);
    rd(4'h6, v); chk(v == 7, "R2 cnt1", v, 7);
    rd(4'h7, v); chk(v == cw(0, 2, 1, 0, 0, 1, 1, 1, 0, 1), "R2 ctl1", v, cw(0, 2, 1, 0, 0, 1, 1, 1, 0, 1));
    repeat (5) @(negedge clk);
    chk(ntx == 0, "R2 no start without enable", 32'(ntx), 0);

    // R6 block timing, R8 completion, R9 interrupt and clear
    plan(0, 32'h000, 32'h100, 5, 2, 0, 0, 0, 0);
    prog(0, 32'h000, 32'h100, 5);
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 1, 0, 0, 1));
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (k == 14) chk(irq[0] == 1'b0, "R6 irq early", irq, 0);
      if (k == 15) chk(irq[0] == 1'b1, "R6 irq at 3N", irq, 1);
    end
    rd(4'h3, v); chk(v[0] == 1'b0, "R8 enable cleared", v, 0);
    rd(4'h2, v); chk(v == 0, "R8 count zero", v, 0);
    rd(4'h0, v); chk(v == 32'h014, "R4 src after word steps", v, 32'h014);
    rd(4'h8, v); chk(v == 1, "R8 done flag", v, 1);
    wr(4'h8, 32'h1);
    rd(4'h8, v); chk(v == 0 && irq == 0, "R9 write-one clears", {v[29:0], irq}, 0);
    cmp("R3 block word copy");

    // R4 byte, both down
    plan(1, 32'h2FF, 32'h3FF, 6, 0, 1, 1, 0, 0);
    prog(1, 32'h2FF, 32'h3FF, 6);
    wr(4'h7, cw(1, 0, 1, 1, 0, 0, 1, 0, 0, 0));
    wait_done(1, "R4 byte down done");
    repeat (2) @(negedge clk);
    chk(irq == 0, "R9 irq masked", irq, 0);
    rd(4'h4, v); chk(v == 32'h2F9, "R4 src stepped down", v, 32'h2F9);
    cmp("R4 byte down copy");
    wr(4'h8, 32'h2);

    // R4 half-word to fixed destination
    plan(0, 32'h020, 32'h1F0, 4, 1, 0, 0, 0, 1);
    prog(0, 32'h020, 32'h1F0, 4);
    wr(4'h3, cw(1, 1, 0, 0, 0, 1, 1, 0, 0, 0));
    wait_done(0, "R4 fixed done");
    repeat (2) @(negedge clk);
    rd(4'h1, v); chk(v == 32'h1F0, "R4 fixed dst held", v, 32'h1F0);
    cmp("R4 fixed copy");
    wr(4'h8, 32'h1);

    // R5 single mode software, burst off
    plan(0, 32'h040, 32'h140, 3, 2, 0, 0, 0, 0);
    prog(0, 32'h040, 32'h140, 3);
    n0 = ntx;
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    rd(4'h2, v); chk(v == 2 && ntx - n0 == 2, "R5 one unit per request", {v[15:0], 16'(ntx - n0)}, {16'd2, 16'd2});
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    rd(4'h2, v); chk(v == 1, "R5 second request", v, 1);
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
    wait_done(0, "R5 single done");
    cmp("R5 single copy");
    wr(4'h8, 32'h1);

    // R5 single mode with burst
    plan(1, 32'h240, 32'h340, 6, 2, 0, 0, 0, 0);
    prog(1, 32'h240, 32'h340, 6);
    n0 = ntx;
    wr(4'h7, cw(1, 2, 0, 0, 0, 0, 0, 1, 0, 0));
    repeat (20) @(negedge clk);
    rd(4'h6, v); chk(v == 2 && ntx - n0 == 8, "R5 burst of four", {v[15:0], 16'(ntx - n0)}, {16'd2, 16'd8});
    wr(4'h7, cw(1, 2, 0, 0, 0, 0, 0, 1, 0, 0));
    wait_done(1, "R5 burst tail done");
    cmp("R5 burst copy");
    wr(4'h8, 32'h2);

    // R11 external single: sync latency, no start from control write
    plan(1, 32'h280, 32'h380, 2, 2, 0, 0, 0, 0);
    prog(1, 32'h280, 32'h380, 2);
    n0 = ntx;
    wr(4'h7, cw(1, 2, 0, 0, 0, 0, 0, 0, 1, 0));
    repeat (5) @(negedge clk);
    chk(ntx == n0, "R11 control write alone", 32'(ntx - n0), 0);
    xreq_n[1] = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k < 4) chk(mem_rd == 1'b0, "R11 no read yet", mem_rd, 0);
      else       chk(mem_rd == 1'b1, "R11 read after sync", mem_rd, 1);
    end
    repeat (4) @(negedge clk);
    xreq_n[1] = 1'b1;
    repeat (10) @(negedge clk);
    rd(4'h6, v); chk(v == 1, "R11 held level is one request", v, 1);
    xreq_n[1] = 1'b0;
    repeat (3) @(negedge clk);
    xreq_n[1] = 1'b1;
    wait_done(1, "R11 second pulse done");
    cmp("R11 copy");
    wr(4'h8, 32'h2);

    // R7 demand mode pause and resume
    plan(0, 32'h080, 32'h180, 12, 2, 0, 0, 0, 0);
    prog(0, 32'h080, 32'h180, 12);
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 2, 0, 1, 0));
    xreq_n[0] = 1'b0;
    repeat (12) @(negedge clk);
    xreq_n[0] = 1'b1;
    repeat (8) @(negedge clk);
    rd(4'h2, v);
    n0 = ntx;
    chk(v > 0 && v < 12, "R7 partial progress", v, 6);
    repeat (20) @(negedge clk);
    ok = int'(reg_rdata == v && ntx == n0);
    chk(ok == 1, "R7 paused", reg_rdata, v);
    xreq_n[0] = 1'b0;
    wait_done(0, "R7 resumed to done");
    xreq_n[0] = 1'b1;
    cmp("R7 demand copy");
    wr(4'h8, 32'h1);

    // R10 fixed priority, unit-level arbitration
    plan(0, 32'h0C0, 32'h1C0, 3, 2, 0, 0, 0, 0);
    plan(1, 32'h2C0, 32'h3C0, 3, 2, 0, 0, 0, 0);
    prog(0, 32'h0C0, 32'h1C0, 3);
    prog(1, 32'h2C0, 32'h3C0, 3);
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 1, 0, 1, 0));
    wr(4'h7, cw(1, 2, 0, 0, 0, 0, 1, 0, 1, 0));
    order.delete();
    xreq_n = 2'b00;
    wait_done(0, "R10 ch0 done");
    wait_done(1, "R10 ch1 done");
    xreq_n = 2'b11;
    ok = 1;
    for (int i = 0; i < 12; i++) if (order.size() != 12 || order[i] != (i < 6 ? 0 : 1)) ok = 0;
    chk(ok == 1, "R10 channel 0 first", 32'(order.size()), 12);
    cmp("R10 both copies");
    wr(4'h8, 32'h3);

    // R10 burst group not split
    plan(1, 32'h2E0, 32'h3E0, 4, 2, 0, 0, 0, 0);
    plan(0, 32'h0E0, 32'h1E0, 2, 2, 0, 0, 0, 0);
    prog(1, 32'h2E0, 32'h3E0, 4);
    prog(0, 32'h0E0, 32'h1E0, 2);
    order.delete();
    wr(4'h7, cw(1, 2, 0, 0, 0, 0, 1, 1, 0, 0));
    wr(4'h3, cw(1, 2, 0, 0, 0, 0, 1, 0, 0, 0));
    wait_done(0, "R10 ch0 after group");
    wait_done(1, "R10 ch1 group done");
    ok = 1;
    for (int i = 0; i < 12; i++) if (order.size() != 12 || order[i] != (i < 8 ? 1 : 0)) ok = 0;
    chk(ok == 1, "R10 burst kept whole", 32'(order.size()), 12);
    cmp("R10 burst copies");
    wr(4'h8, 32'h3);

    finish_run();
  end
endmodule